// File: doc/BRIEF.md
# Gated Frequency Counter

This block measures the frequency of an external signal by counting its rising edges inside a gate window of known length. Software selects a window length and writes a control byte whose low bit opens the window. The count is then read once the status flag shows the window has closed. A second control bit zeroes the count. A sticky flag records that the count ran past its top value.

Window lengths are whole multiples of a base tick. The base tick is derived from the system clock by a prescaler of `TICK_DIV` cycles, so the default of 125000 at 125 MHz gives a 1 ms tick. One selection keeps the window open with no limit.

Two power-mode inputs act on the block. Stop mode returns all state to zero. Halt mode freezes the block exactly as it was.

Top module: `freq_gate_counter`

## Requirements
- R1: A control write with bit 0 set opens the gate, so the status output reads 1 on the following cycle. Writes with bit 0 clear do not open the gate.
- R2: A control write with bit 1 set returns the count and the overflow flag to zero on the following cycle. Writes with bit 1 clear leave them untouched.
- R3: The gate length is sampled at the start write. For `gate_sel` 00, 01 and 10 the gate closes exactly 1, 4 and 8 times `TICK_DIV` cycles after the start write.
- R4: With `gate_sel` 11 at the start write, the gate stays open until stop mode or reset.
- R5: Each rising edge of `sig_in` reaches the counter after a two-flop synchronizer and an edge detector. A rising edge is counted only if the gate is open in the cycle its detected edge arrives, which is three clocks after sampling.
- R6: When the count sits at its maximum, a further counted edge leaves the count at maximum and sets the overflow flag. The flag stays set until a clear. The gate still stays open until its selected time runs out.
- R7: A write with both bit 0 and bit 1 set zeroes the count and opens a fresh gate window in the same cycle. An edge arriving in that cycle is not counted.
- R8: A start write while the gate is already open restarts the full gate time and keeps the count.
- R9: While `stop_mode` is high, the gate, count and overflow flag are forced to zero and control writes are ignored.
- R10: While `halt_mode` is high (and `stop_mode` low), the gate, count, overflow flag and gate timer hold their values and control writes are ignored.
- R11: `status_rdata` bit 0 shows the gate state, and bits 7 to 1 always read 0. Control bits 7 to 2 have no effect.
- R12: After reset the status, count and overflow outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_mode | input | 1 | Stop mode: clears all state |
| halt_mode | input | 1 | Halt mode: freezes all state |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control byte: bit 0 start, bit 1 clear |
| gate_sel | input | 2 | Gate length: 00 1 tick, 01 4 ticks, 10 8 ticks, 11 unlimited |
| sig_in | input | 1 | Signal to be measured (asynchronous) |
| status_rdata | output | 8 | Status byte, bit 0 = gate open |
| count_val | output | CNT_W | Edge count |
| count_ovf | output | 1 | Sticky overflow flag |

## Verification
The bench targets several failure modes:
- **Gate length off by one.** A gate timer that is one cycle long or short shows up as a status bit that falls at the wrong clock.
- **Overflow that closes the gate.** Driving enough edges into a finite window to pass the maximum catches a counter that wraps to zero, or a design that ends the window early once the count saturates.
- **Restart while open.** Restarting a running window catches a design that zeroes the count on a restart or keeps the old end time.
- **Start and clear in one write.** This catches a design that counts an edge in the write cycle.
- **Halt and stop.** Writes and edges during halt catch state that drifts while frozen. Writes during stop catch writes that leak through.

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
  parameter int TICK_DIV = 125000,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_mode,
  input  logic             halt_mode,
  input  logic             ctrl_we,
  input  logic [7:0]       ctrl_wdata,
  input  logic [1:0]       gate_sel,
  input  logic             sig_in,
  output logic [7:0]       status_rdata,
  output logic [CNT_W-1:0] count_val,
  output logic             count_ovf
);

  localparam int              PW     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0]   P_LAST = PW'(TICK_DIV - 1);
  localparam logic [CNT_W-1:0] C_MAX = '1;

  logic             s1, s2, s3;
  logic             gate_open, gate_inf;
  logic [3:0]       ticks_left, sel_ticks;
  logic [PW-1:0]    presc;
  logic [CNT_W-1:0] cnt;
  logic             ovf;

  wire act      = !halt_mode && !stop_mode;
  wire wr_start = act && ctrl_we && ctrl_wdata[0];
  wire wr_clear = act && ctrl_we && ctrl_wdata[1];
  wire rise     = s2 && !s3;
  wire tick     = (presc == P_LAST);

  always_comb
    case (gate_sel)
      2'b00:   sel_ticks = 4'd1;
      2'b01:   sel_ticks = 4'd4;
      default: sel_ticks = 4'd8;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {sig_in, s1, s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || stop_mode) begin
      gate_open  <= 1'b0;
      gate_inf   <= 1'b0;
      ticks_left <= '0;
      presc      <= '0;
    end else if (!halt_mode) begin
      if (wr_start) begin
        gate_open  <= 1'b1;
        gate_inf   <= (gate_sel == 2'b11);
        ticks_left <= sel_ticks;
        presc      <= '0;
      end else if (gate_open && !gate_inf) begin
        if (tick) begin
          presc      <= '0;
          ticks_left <= ticks_left - 4'd1;
          if (ticks_left == 4'd1) gate_open <= 1'b0;
        end else begin
          presc <= presc + 1'b1;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || stop_mode) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (!halt_mode) begin
      if (wr_clear) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (gate_open && rise) begin
        if (cnt == C_MAX) ovf <= 1'b1;
        else              cnt <= cnt + 1'b1;
      end
    end

  assign status_rdata = {7'b0, gate_open};
  assign count_val    = cnt;
  assign count_ovf    = ovf;

  assert_start_opens_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[0] && !halt_mode && !stop_mode) |=> status_rdata[0]);

  assert_clear_zeroes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[1] && !halt_mode && !stop_mode) |=> (count_val == '0 && !count_ovf));

  assert_open_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_open && gate_inf && !stop_mode) |=> status_rdata[0]);

  assert_saturate_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_val == C_MAX && !wr_clear && !stop_mode) |=> count_val == C_MAX);

  assert_sticky_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_ovf && !wr_clear && !stop_mode) |=> count_ovf);

  assert_stop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_mode |=> (status_rdata == 8'h00 && count_val == '0 && !count_ovf));

  assert_halt_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_mode && !stop_mode) |=> ($stable(count_val) && $stable(status_rdata) && $stable(count_ovf)));

endmodule

// File: tb/test_freq_gate_counter.sv
`timescale 1ns/1ps
module test_freq_gate_counter;
  localparam int DIV = 80;
  localparam int CW  = 8;
  localparam int MAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, stop_mode = 0, halt_mode = 0, ctrl_we = 0, sig_in = 0;
  logic [7:0] ctrl_wdata = 0;
  logic [1:0] gate_sel = 0;
  logic [7:0] status_rdata;
  logic [CW-1:0] count_val;
  logic count_ovf;

  freq_gate_counter #(.TICK_DIV(DIV), .CNT_W(CW)) i_freq_gate_counter (
    .clk(clk), .rst_n(rst_n), .stop_mode(stop_mode), .halt_mode(halt_mode),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .gate_sel(gate_sel), .sig_in(sig_in),
    .status_rdata(status_rdata), .count_val(count_val), .count_ovf(count_ovf));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  string req = "R12";

  // behavioural reference model
  int m_cnt = 0, m_rem = 0;
  bit m_open = 0, m_inf = 0, m_ovf = 0, m_rise;
  bit hist[$] = '{0, 0, 0};

  function automatic int gate_cycles(logic [1:0] s);
    return (s == 2'b00 ? 1 : s == 2'b01 ? 4 : 8) * DIV;
  endfunction

  always @(posedge clk) begin
    m_rise = hist[1] && !hist[2];
    if (!rst_n) begin
      m_cnt = 0; m_rem = 0; m_open = 0; m_inf = 0; m_ovf = 0;
      hist = '{0, 0, 0};
    end else begin
      if (stop_mode) begin
        m_cnt = 0; m_rem = 0; m_open = 0; m_inf = 0; m_ovf = 0;
      end else if (!halt_mode) begin
        if (ctrl_we && ctrl_wdata[1]) begin
          m_cnt = 0; m_ovf = 0;
        end else if (m_open && m_rise) begin
          if (m_cnt == MAX) m_ovf = 1; else m_cnt++;
        end
        if (ctrl_we && ctrl_wdata[0]) begin
          m_open = 1; m_inf = (gate_sel == 2'b11); m_rem = gate_cycles(gate_sel);
        end else if (m_open && !m_inf) begin
          m_rem--;
          if (m_rem == 0) m_open = 0;
        end
      end
      hist.push_front(sig_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    checks++;
    if (status_rdata !== {7'b0, m_open}) begin
      errors++;
      $display("FAIL %s status actual %h expected %h", req, status_rdata, {7'b0, m_open});
    end
    checks++;
    if (count_val !== CW'(m_cnt)) begin
      errors++;
      $display("FAIL %s count actual %0d expected %0d", req, count_val, m_cnt);
    end
    checks++;
    if (count_ovf !== m_ovf) begin
      errors++;
      $display("FAIL %s overflow actual %0b expected %0b", req, count_ovf, m_ovf);
    end
  end

  // stimulus for the measured signal
  bit tog_en = 0;
  int tog_per = 2, tog_cnt = 0;
  always @(negedge clk)
    if (tog_en) begin
      tog_cnt++;
      if (tog_cnt >= tog_per) begin
        tog_cnt = 0;
        sig_in <= ~sig_in;
      end
    end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk);
    ctrl_we = 1; ctrl_wdata = d;
    @(negedge clk);
    ctrl_we = 0; ctrl_wdata = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired in %s", req);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    req = "R12"; idle(4); rst_n = 1; idle(3);
    req = "R11"; tog_en = 1; wr(8'hFC); idle(20);
    req = "R1";  gate_sel = 2'b00; wr(8'h01); idle(40);
    req = "R3";  idle(60);
    req = "R5";  gate_sel = 2'b01; wr(8'h01); idle(400);
    req = "R8";  gate_sel = 2'b10; wr(8'h01); idle(300); wr(8'h01); idle(700);
    req = "R2";  wr(8'h02); idle(10); wr(8'h00); idle(5);
    req = "R7";  gate_sel = 2'b00; wr(8'h01); idle(30); wr(8'h03); idle(100);
    req = "R10"; gate_sel = 2'b10; wr(8'h01); idle(50);
    halt_mode = 1; idle(5); wr(8'h03); idle(20); halt_mode = 0; idle(700);
    req = "R9";  gate_sel = 2'b11; wr(8'h01); idle(40);
    stop_mode = 1; idle(3); wr(8'h01); stop_mode = 0; idle(10);
    req = "R4";  gate_sel = 2'b11; wr(8'h01); idle(600);
    req = "R6";  tog_per = 1; gate_sel = 2'b10; wr(8'h03); idle(700);
    wr(8'h02); idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule